// File: doc/BRIEF.md
# Parallel Flash Sector-Erase Command Decoder

This block is the write-command front end of a byte-wide parallel flash device with a 19-bit address and an 8-bit data bus. It samples the active-low chip-enable and write-enable strobes with a system clock and treats each low pulse of write-enable, made while the chip is enabled, as one bus write. From the stream of such writes it picks out a six-write sector-erase command and a four-write byte-program command. The erase command takes the target sector from the address present when write-enable falls on its last write. It takes the command byte from the data present when that same strobe rises.

When a command is accepted, the block raises a busy state. For an erase the busy state lasts a parameterised number of clocks, and for a program it lasts a shorter parameterised number. The block tells a downstream status generator which kind of operation is running. All writes are dropped while it is busy. When an erase ends, the block sets one flag per 4 KB sector to record that the sector now reads as all FFh. Sectors are selected by the address bits above bit 11, which gives 128 sectors.

Top module: `pfc_top`

## Requirements
- R1: After reset, busy, op_erase and op_program are 0 and every bit of erased_map is 0.
- R2: A bus write begins when we_n falls while ce_n is low, and it completes when we_n rises while ce_n is still low. A we_n pulse made with ce_n high is not a write and does not advance or disturb a command in progress.
- R3: The erase command is these six writes, with the address compared on bits [11:0] and the upper bits free: AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, then 30h at any address in the target sector.
- R4: The erased sector is addr[18:12] as sampled when we_n falls on the sixth write. An address change before we_n rises has no effect.
- R5: The command byte of the sixth write is the data sampled when we_n rises. A different value present at the falling edge has no effect.
- R6: busy rises on the clock after the rising edge of the completing write is sampled. For an erase it stays high for exactly ERASE_CYCLES clocks, with op_erase high and op_program low throughout.
- R7: In the clock where an erase's busy falls, the erased_map bit of the selected sector sets. No other bit of erased_map changes, and erased_map never changes at any other time.
- R8: A wrong address or a wrong data byte on any of the command writes returns the decoder to idle and starts no operation.
- R9: While busy, every write is ignored. No operation starts, erased_map is unaffected, and after busy ends the decoder is idle, so a lone final command write starts nothing.
- R10: The program command is AAh at 555h, 55h at 2AAh, A0h at 555h, then a write of any address and data. It holds busy for exactly PROG_CYCLES clocks with op_program high and op_erase low, and leaves erased_map unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 19 | Byte address |
| data | input | 8 | Write data byte |
| busy | output | 1 | An internal program or erase is running |
| op_erase | output | 1 | The running operation is an erase |
| op_program | output | 1 | The running operation is a program |
| erased_map | output | 128 | One flag per sector, set when that sector has been erased |

## Verification
On every cycle, the assertions check four things. A busy period may begin only right after a sampled rising edge of write-enable with chip-enable low. The operation kind stays fixed and matches busy throughout a busy period. Sector flags only ever set. Any change to the flags comes, one bit at a time, at the end of an erase. Other behaviour depends on the command history, so only the bench scenarios can show it: which sector gets marked, that the address is taken on the falling edge and the command byte on the rising edge, the exact busy length, each mismatch position, and the return to idle after writes are dropped. The bench sweeps all 128 sectors and every corrupted position of the command.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_UNL1, ST_UNL2, ST_ERA1, ST_ERA2, ST_ERA3, ST_PROG
   } seq_t;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2
   } op_t;

   localparam logic [11:0] KEY_ADDR_A = 12'h555;
   localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
   localparam logic [7:0]  KEY_AA     = 8'hAA;
   localparam logic [7:0]  KEY_55     = 8'h55;
   localparam logic [7:0]  CMD_ERASE  = 8'h80;
   localparam logic [7:0]  CMD_PROG   = 8'hA0;
   localparam logic [7:0]  CMD_SECTOR = 8'h30;
endpackage

// File: rtl/pfc_strobe.sv
module pfc_strobe #(
   parameter int ADDR_W      = 19,
   parameter int SECTOR_BITS = 12,
   localparam int SEL_W      = ADDR_W - SECTOR_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ce_n,
   input  logic                   we_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             data,
   output logic                   fire,
   output logic [SECTOR_BITS-1:0] offs_q,
   output logic [SEL_W-1:0]       sect_q,
   output logic [7:0]             cmd
);
   logic we_q;
   logic armed;
   logic fall_seen;
   logic rise_seen;

   assign fall_seen = we_q & ~we_n & ~ce_n;
   assign rise_seen = ~we_q & we_n;
   assign fire      = rise_seen & armed & ~ce_n;
   assign cmd       = data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q   <= 1'b1;
         armed  <= 1'b0;
         offs_q <= '0;
         sect_q <= '0;
      end else begin
         we_q <= we_n;
         if (fall_seen) begin
            armed  <= 1'b1;
            offs_q <= addr[SECTOR_BITS-1:0];
            sect_q <= addr[ADDR_W-1:SECTOR_BITS];
         end else if (rise_seen) begin
            armed  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
   import pfc_pkg::*;
#(
   parameter int SECTOR_BITS = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fire,
   input  logic                   lock,
   input  logic [SECTOR_BITS-1:0] offs,
   input  logic [7:0]             cmd,
   output logic                   start,
   output op_t                    start_op
);
   seq_t state, state_nx;
   logic at_a, at_b;

   assign at_a = (offs == SECTOR_BITS'(KEY_ADDR_A));
   assign at_b = (offs == SECTOR_BITS'(KEY_ADDR_B));

   always_comb begin
      state_nx = state;
      start    = 1'b0;
      start_op = OP_NONE;
      if (lock) begin
         state_nx = ST_IDLE;
      end else if (fire) begin
         state_nx = ST_IDLE;
         unique case (state)
            ST_IDLE: if (at_a && cmd == KEY_AA) state_nx = ST_UNL1;
            ST_UNL1: if (at_b && cmd == KEY_55) state_nx = ST_UNL2;
            ST_UNL2: begin
               if (at_a && cmd == CMD_ERASE)     state_nx = ST_ERA1;
               else if (at_a && cmd == CMD_PROG) state_nx = ST_PROG;
            end
            ST_ERA1: if (at_a && cmd == KEY_AA) state_nx = ST_ERA2;
            ST_ERA2: if (at_b && cmd == KEY_55) state_nx = ST_ERA3;
            ST_ERA3: begin
               if (cmd == CMD_SECTOR) begin
                  start    = 1'b1;
                  start_op = OP_ERASE;
               end
            end
            ST_PROG: begin
               start    = 1'b1;
               start_op = OP_PROG;
            end
            default: state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/pfc_timer.sv
module pfc_timer
   import pfc_pkg::*;
#(
   parameter int ERASE_CYCLES = 4000,
   parameter int PROG_CYCLES  = 20,
   localparam int MAXC        = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
   localparam int CW          = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  op_t  start_op,
   output logic busy,
   output op_t  kind,
   output logic done
);
   logic [CW-1:0] cnt;

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         kind <= OP_NONE;
      end else if (start) begin
         cnt  <= (start_op == OP_ERASE) ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
         kind <= start_op;
      end else if (busy) begin
         cnt <= cnt - CW'(1);
         if (done) kind <= OP_NONE;
      end
   end
endmodule

// File: rtl/pfc_top.sv
module pfc_top
   import pfc_pkg::*;
#(
   parameter int ADDR_W       = 19,
   parameter int SECTOR_BITS  = 12,
   parameter int ERASE_CYCLES = 4000,
   parameter int PROG_CYCLES  = 20,
   localparam int SEL_W       = ADDR_W - SECTOR_BITS,
   localparam int NUM_SECT    = 1 << SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n,
   input  logic                we_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [7:0]          data,
   output logic                busy,
   output logic                op_erase,
   output logic                op_program,
   output logic [NUM_SECT-1:0] erased_map
);
   if (SECTOR_BITS < 12) begin : g_bad_sector
      $error("SECTOR_BITS must cover the 12-bit unlock offsets");
   end
   if (SEL_W < 1 || SEL_W > 10) begin : g_bad_sel
      $error("sector select width must be 1 to 10 bits");
   end
   if (ERASE_CYCLES < 1 || PROG_CYCLES < 1) begin : g_bad_time
      $error("operation durations must be at least one clock");
   end

   logic                   fire;
   logic [SECTOR_BITS-1:0] offs_q;
   logic [SEL_W-1:0]       sect_q;
   logic [7:0]             cmd;
   logic                   start;
   op_t                    start_op;
   op_t                    kind;
   logic                   done;
   logic [SEL_W-1:0]       target_q;

   pfc_strobe #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .data(data), .fire(fire), .offs_q(offs_q), .sect_q(sect_q), .cmd(cmd)
   );

   pfc_seq #(.SECTOR_BITS(SECTOR_BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .fire(fire), .lock(busy), .offs(offs_q),
      .cmd(cmd), .start(start), .start_op(start_op)
   );

   pfc_timer #(.ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
      .busy(busy), .kind(kind), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             target_q <= '0;
      else if (start && start_op == OP_ERASE) target_q <= sect_q;
   end

   assign op_erase   = busy && (kind == OP_ERASE);
   assign op_program = busy && (kind == OP_PROG);

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            erased_map[i] <= 1'b0;
         else if (done && kind == OP_ERASE && target_q == SEL_W'(i))
            erased_map[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
   parameter int NUM_SECT = 128
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ce_n,
   input logic                we_n,
   input logic                busy,
   input logic                op_erase,
   input logic                op_program,
   input logic [NUM_SECT-1:0] erased_map
);
   // R6
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(we_n) && !$past(we_n, 2) && !$past(ce_n)));

   // R6
   kind_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_erase, op_program}) && (busy == (op_erase || op_program)));

   // R9
   kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_erase) && $stable(op_program)));

   // R7
   map_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(erased_map) & ~erased_map) == '0));

   // R7
   map_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(erased_map) |->
         ($fell(busy) && $past(op_erase) && $countones(erased_map ^ $past(erased_map)) == 1));
endmodule

bind pfc_top pfc_chk #(.NUM_SECT(NUM_SECT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .busy(busy),
   .op_erase(op_erase), .op_program(op_program), .erased_map(erased_map)
);

// File: tb/tb_pfc_top.sv
`timescale 1ns/1ps
module tb_pfc_top;
   localparam int ERASE_N = 120;
   localparam int PROG_N  = 10;
   localparam int NS      = 128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ce_n = 1'b1;
   logic           we_n = 1'b1;
   logic [18:0]    addr = '0;
   logic [7:0]     data = '0;
   logic           busy, op_erase, op_program;
   logic [NS-1:0]  erased_map;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   // busy-run monitor
   int  run = 0, last_run = 0, runs = 0;
   bit  in_run = 0, se = 0, sp = 0, saw_e = 0, saw_p = 0;

   pfc_top #(.ERASE_CYCLES(ERASE_N), .PROG_CYCLES(PROG_N)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .data(data), .busy(busy), .op_erase(op_erase), .op_program(op_program),
      .erased_map(erased_map)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (busy) begin
         if (!in_run) begin run = 0; se = 0; sp = 0; end
         in_run = 1; run++; se |= op_erase; sp |= op_program;
      end else if (in_run) begin
         in_run = 0; last_run = run; saw_e = se; saw_p = sp; runs++;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic wr(input logic [18:0] af, input logic [7:0] df,
                     input logic [18:0] ar, input logic [7:0] dr, input bit ce_hi);
      @(negedge clk) ce_n = ce_hi; addr = af; data = df;
      @(negedge clk) we_n = 1'b0;
      @(negedge clk);
      @(negedge clk) addr = ar; data = dr;
      @(negedge clk) we_n = 1'b1;
      @(negedge clk) ce_n = 1'b1;
   endtask

   task automatic wr1(input logic [18:0] a, input logic [7:0] d);
      wr(a, d, a, d, 1'b0);
   endtask

   // bad_kind: 0 none, 1 data corrupted, 2 address corrupted, 3 ce_n high
   task automatic erase_seq(input int s, input int noise, input int bad_pos, input int bad_kind);
      logic [11:0] offs [5];
      logic [7:0]  vals [5];
      offs = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA};
      vals = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
      for (int i = 0; i < 5; i++) begin
         logic [11:0] o = offs[i];
         logic [7:0]  v = vals[i];
         if (bad_pos == i && bad_kind == 1) v = v ^ 8'h01;
         if (bad_pos == i && bad_kind == 2) o = o ^ 12'h800;
         wr1({7'(noise + i), o}, v);
      end
      begin
         logic [7:0] v6 = 8'h30;
         if (bad_pos == 5 && bad_kind == 1) v6 = 8'h31;
         wr({7'(s), 12'h0AB}, 8'h00, {~7'(s), 12'h555}, v6, bad_pos == 5 && bad_kind == 3);
      end
   endtask

   task automatic prog_seq(input logic [18:0] a, input logic [7:0] d);
      wr1({7'h11, 12'h555}, 8'hAA);
      wr1({7'h22, 12'h2AA}, 8'h55);
      wr1({7'h33, 12'h555}, 8'hA0);
      wr1(a, d);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4 * ERASE_N && (busy || in_run); i++) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [NS-1:0] mask_upto(input int s);
      logic [NS-1:0] m = '0;
      for (int i = 0; i <= s; i++) m[i] = 1'b1;
      return m;
   endfunction

   initial begin
      #(2_000_000);
      chk(1'b0, "watchdog", 0, 1);
      finish_up();
   end

   initial begin
      int r0;
      logic [NS-1:0] m0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!busy && !op_erase && !op_program && erased_map == '0, "R1 reset",
          {busy, op_erase, op_program}, 0);

      // R8: corrupted data on each position, corrupted address on each unlock write
      for (int k = 1; k <= 2; k++) begin
         for (int p = 0; p < 6; p++) begin
            if (k == 2 && p == 5) continue;
            r0 = runs;
            erase_seq(3, 9 * p, p, k);
            repeat (8) @(negedge clk);
            chk(runs == r0 && !busy && erased_map == '0, $sformatf("R8 pos%0d kind%0d", p, k),
                runs - r0, 0);
         end
      end

      // R2: sixth pulse with ce_n high does nothing; next real final write completes (R3)
      r0 = runs;
      erase_seq(0, 40, 5, 3);
      repeat (8) @(negedge clk);
      chk(runs == r0 && !busy, "R2 ce_n high pulse ignored", runs - r0, 0);
      wr({7'd0, 12'h7FF}, 8'h30, {7'd0, 12'h7FF}, 8'h30, 1'b0);
      wait_idle();
      chk(runs == r0 + 1 && last_run == ERASE_N, "R2 held state then erase", last_run, ERASE_N);
      chk(erased_map == mask_upto(0), "R3 sector0 erased", erased_map, mask_upto(0));

      // R10: program
      m0 = erased_map;
      prog_seq({7'h45, 12'h321}, 8'h5A);
      wait_idle();
      chk(last_run == PROG_N, "R10 program length", last_run, PROG_N);
      chk(saw_p && !saw_e, "R10 program kind", {saw_p, saw_e}, 2);
      chk(erased_map == m0, "R10 map unchanged", erased_map, m0);

      // R3..R7, R9: sweep all sectors
      for (int s = 0; s < NS; s++) begin
         bool_block: begin
            bit interfere = (s % 2 == 0) && (s < NS - 1);
            erase_seq(s, (s * 37) % 128, -1, 0);
            @(negedge clk);
            chk(busy && op_erase && !op_program, $sformatf("R6 busy s%0d", s),
                {busy, op_erase, op_program}, 3'b110);
            if (interfere) begin
               erase_seq(s + 1, s, -1, 0);
               prog_seq({7'(s), 12'h010}, 8'h00);
            end
            wait_idle();
            chk(last_run == ERASE_N && saw_e && !saw_p, $sformatf("R6 length s%0d", s),
                last_run, ERASE_N);
            // R4 R5 R7: only bits 0..s set
            chk(erased_map == mask_upto(s), $sformatf("R7 map s%0d", s),
                erased_map, mask_upto(s));
            if (interfere) begin
               r0 = runs;
               wr1({7'(s + 1), 12'h000}, 8'h30);
               repeat (6) @(negedge clk);
               chk(runs == r0 && !busy, $sformatf("R9 idle after busy s%0d", s), runs - r0, 0);
            end
         end
      end
      finish_up();
   end
endmodule